// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the two timing strobes a UART needs from the module clock. The first is a 16x oversampling enable. The second is a once-per-bit enable that lines up with every sixteenth oversampling enable. The divide ratio has a 13-bit integer part. Added to it is a 5-bit fraction counted in thirty-seconds, so the average bit rate is clk / (16 x (SBR + F/32)).

A byte-wide write port with a 2-bit address loads the divisor and the fraction:

| Address | Write | Effect |
|---------|-------|--------|
| 0 | Upper five divisor bits, in bits [4:0] | Staged only |
| 1 | Lower eight divisor bits | Commits the divisor and restarts the tick phase |
| 2 | Fraction, in bits [4:0] | Takes effect at once |

Both strobes stay quiet while the committed divisor is zero.

The fraction works through a 5-bit accumulator. F is added to it on every sample tick, and a carry out lengthens the next sample interval by one clock. The extra clocks are therefore spread evenly through each bit time rather than bunched at its end.

Top module: `fractional_baud_gen`

## Requirements
- R1: After reset the committed divisor is zero and both `sample_tick` and `bit_tick` are low.
- R2: A write to address 1 commits the divisor {staged upper five bits, wr_data[7:0]} and restarts the phase: prescaler, sample index and accumulator all clear. Bits [7:5] of an address 0 write are ignored.
- R3: A write to address 0 alone never changes the committed divisor or the tick timing, whether the block is idle or running.
- R4: While the committed divisor is zero, neither output pulses.
- R5: With divisor S and fraction F, the n-th sample tick (n >= 1) after a commit is high in the cycle ending n*S + floor((n-1)*F/32) clocks after the commit edge. Each interval is S or S+1 clocks.
- R6: Address 2 sets the fraction from wr_data[4:0] and ignores bits [7:5].
- R7: `bit_tick` is high together with every 16th sample tick counted from the commit, and at no other time.
- R8: With S = 1 and F = 0, `sample_tick` is high on every clock and `bit_tick` on every 16th clock, which is the maximum rate of clk/16 bits per second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 2 | Register select: 0 upper divisor, 1 lower divisor and commit, 2 fraction |
| wr_data | input | 8 | Write data byte |
| sample_tick | output | 1 | 16x oversampling enable |
| bit_tick | output | 1 | One-per-bit enable, on every 16th sample tick |

## Verification
Both strobes are decoded without a register from the prescaler state. The commit clears that state on its own clock edge, so the first sample tick is visible S-1 cycles after the commit edge, and tick n is visible T(n)-1 cycles after it, where T(n) = n*S + floor((n-1)*F/32). Each stream task starts counting at the falling edge that follows the commit edge. It compares both outputs on every falling edge against this closed form, which the bench computes on its own. Checks that need no particular phase, such as an ignored upper-byte write or a zero divisor, count ticks or tick spacing over a window instead.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int SBR_W_DEF  = 13;
    localparam int FRAC_W_DEF = 5;
    localparam int OSR_LOG2   = 4;
    localparam int ADDR_W     = 2;
    localparam int BYTE_W     = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIV_HI = 2'd0,
        REG_DIV_LO = 2'd1,
        REG_FRAC   = 2'd2,
        REG_NONE   = 2'd3
    } fbg_reg_e;

    typedef struct packed {
        logic              en;
        fbg_reg_e          sel;
        logic [BYTE_W-1:0] data;
    } fbg_wr_t;

    function automatic logic is_write(input fbg_wr_t w, input fbg_reg_e r);
        return w.en && (w.sel == r);
    endfunction
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
    import fbg_pkg::*;
#(
    parameter int SBR_W  = SBR_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  fbg_wr_t           wr,
    output logic [SBR_W-1:0]  sbr_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic              commit
);
    localparam int HI_W = SBR_W - BYTE_W;

    logic [HI_W-1:0] hi_stage;
    logic [BYTE_W-HI_W-1:0] unused_hi_bits;
    logic [BYTE_W-FRAC_W-1:0] unused_frac_bits;

    assign unused_hi_bits   = wr.data[BYTE_W-1:HI_W];
    assign unused_frac_bits = wr.data[BYTE_W-1:FRAC_W];
    assign commit           = is_write(wr, REG_DIV_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_stage <= '0;
            sbr_q    <= '0;
            frac_q   <= '0;
        end else begin
            if (is_write(wr, REG_DIV_HI))
                hi_stage <= wr.data[HI_W-1:0];
            if (commit)
                sbr_q <= {hi_stage, wr.data};
            if (is_write(wr, REG_FRAC))
                frac_q <= wr.data[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/fbg_frac_accum.sv
module fbg_frac_accum #(
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              stretch
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, frac};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc     <= '0;
            stretch <= 1'b0;
        end else if (step) begin
            acc     <= sum[FRAC_W-1:0];
            stretch <= sum[FRAC_W];
        end
    end
endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
    parameter int SBR_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [SBR_W-1:0] sbr,
    input  logic             stretch,
    output logic [SBR_W:0]   pcnt,
    output logic             sample_tick
);
    logic           run;
    logic [SBR_W:0] last;

    assign run         = (sbr != '0);
    assign last        = {1'b0, sbr} + {{SBR_W{1'b0}}, stretch} - 1'b1;
    assign sample_tick = run && (pcnt == last);

    always_ff @(posedge clk) begin
        if (rst || clear || !run)
            pcnt <= '0;
        else if (sample_tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/fbg_bit_counter.sv
module fbg_bit_counter #(
    parameter int OSR_LOG2 = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample_tick,
    output logic bit_tick
);
    logic [OSR_LOG2-1:0] sidx;

    assign bit_tick = sample_tick && (sidx == '1);

    always_ff @(posedge clk) begin
        if (rst || clear)
            sidx <= '0;
        else if (sample_tick)
            sidx <= sidx + 1'b1;
    end
endmodule

// File: rtl/fractional_baud_gen.sv
module fractional_baud_gen
    import fbg_pkg::*;
#(
    parameter int SBR_W  = SBR_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              sample_tick,
    output logic              bit_tick
);
    fbg_wr_t           wr;
    logic [SBR_W-1:0]  sbr_q;
    logic [FRAC_W-1:0] frac_q;
    logic              commit;
    logic              stretch;
    logic              idle_clr;
    logic [SBR_W:0]    pcnt;

    assign wr.en    = wr_en;
    assign wr.sel   = fbg_reg_e'(wr_addr);
    assign wr.data  = wr_data;
    assign idle_clr = commit || (sbr_q == '0);

    fbg_regs #(.SBR_W(SBR_W), .FRAC_W(FRAC_W)) u_regs (
        .clk(clk), .rst(rst), .wr(wr),
        .sbr_q(sbr_q), .frac_q(frac_q), .commit(commit)
    );

    fbg_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk(clk), .rst(rst), .clear(idle_clr), .step(sample_tick),
        .frac(frac_q), .stretch(stretch)
    );

    fbg_prescaler #(.SBR_W(SBR_W)) u_presc (
        .clk(clk), .rst(rst), .clear(commit), .sbr(sbr_q),
        .stretch(stretch), .pcnt(pcnt), .sample_tick(sample_tick)
    );

    fbg_bit_counter #(.OSR_LOG2(OSR_LOG2)) u_bits (
        .clk(clk), .rst(rst), .clear(idle_clr),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );
endmodule

// File: rtl/fractional_baud_gen_chk.sv
module fractional_baud_gen_chk #(
    parameter int SBR_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             sample_tick,
    input logic             bit_tick,
    input logic [SBR_W-1:0] sbr_q,
    input logic             commit,
    input logic [SBR_W:0]   pcnt
);
    logic [3:0] seen;

    always_ff @(posedge clk) begin
        if (rst || commit || sbr_q == '0)
            seen <= '0;
        else if (sample_tick)
            seen <= seen + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!sample_tick && !bit_tick && sbr_q == '0));

    p_commit_restart_r2: assert property (@(posedge clk) disable iff (rst)
        commit |=> (pcnt == '0));

    p_hi_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0) |=> $stable(sbr_q));

    p_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (sbr_q == '0) |-> (!sample_tick && !bit_tick));

    p_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && sbr_q > 1 && !commit) |=> !sample_tick);

    p_bit_on_sample_r7: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (sample_tick && seen == 4'd15));
endmodule

bind fractional_baud_gen fractional_baud_gen_chk #(.SBR_W(SBR_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .sample_tick(sample_tick), .bit_tick(bit_tick),
    .sbr_q(sbr_q), .commit(commit), .pcnt(pcnt)
);

// File: tb/fractional_baud_gen_test.sv
module fractional_baud_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       sample_tick;
    logic       bit_tick;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fractional_baud_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Ends at the falling edge right after the write's clock edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int tick_end(input int n, input int s, input int f);
        return n * s + ((n - 1) * f) / 32;
    endfunction

    // Called at the falling edge c=0 right after a commit edge.
    task automatic run_stream(input int s, input int f, input int ncyc,
                              input string req);
        int nxt = 1;
        int es = 0, eb = 0, fs = -1, fb = -1;
        for (int c = 0; c < ncyc; c++) begin
            bit exp_s = (c == tick_end(nxt, s, f) - 1);
            bit exp_b = exp_s && (nxt % 16 == 0);
            if (sample_tick !== exp_s) begin es++; if (fs < 0) fs = c; end
            if (bit_tick !== exp_b) begin eb++; if (fb < 0) fb = c; end
            if (exp_s) nxt++;
            @(negedge clk);
        end
        check(es == 0, req, $sformatf("sample_tick S=%0d F=%0d first bad cycle %0d mismatches", s, f, fs), es, 0);
        check(eb == 0, "R7", $sformatf("bit_tick S=%0d F=%0d first bad cycle %0d mismatches", s, f, fb), eb, 0);
    endtask

    task automatic count_ticks(input int ncyc, output int ns, output int nb);
        ns = 0; nb = 0;
        for (int c = 0; c < ncyc; c++) begin
            if (sample_tick) ns++;
            if (bit_tick) nb++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int ns, nb;
        check(sample_tick == 1'b0 && bit_tick == 1'b0, "R1", "outputs in reset", int'(sample_tick), 0);
        @(negedge clk); rst = 1'b0;
        count_ticks(40, ns, nb);
        check(ns == 0 && nb == 0, "R1", "ticks after reset, zero divisor", ns + nb, 0);
    endtask

    task automatic t_hi_only_idle();
        int ns, nb;
        wr(2'd0, 8'h03);
        count_ticks(60, ns, nb);
        check(ns == 0, "R3", "ticks after upper-byte write only", ns, 0);
    endtask

    task automatic t_basic();
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hE0);             // R2: bits [7:5] ignored, upper part = 0
        wr(2'd1, 8'h04);
        run_stream(4, 0, 200, "R2");
    endtask

    task automatic t_half_frac();
        wr(2'd2, 8'hF0);             // R6: fraction = 16
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h04);
        run_stream(4, 16, 400, "R6");
    endtask

    task automatic t_max_rate();
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h01);
        run_stream(1, 0, 100, "R8");
    endtask

    task automatic t_odd_fracs();
        wr(2'd2, 8'h1F);
        wr(2'd1, 8'h01);
        run_stream(1, 31, 300, "R5");
        wr(2'd2, 8'h05);
        wr(2'd1, 8'h03);
        run_stream(3, 5, 700, "R5");
    endtask

    task automatic t_large();
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h1F);
        wr(2'd1, 8'hFF);
        run_stream(8191, 0, 16400, "R2");
    endtask

    task automatic t_hi_while_running();
        int last = -1, bad = 0, cnt = 0;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h05);
        for (int c = 0; c < 300; c++) begin
            if (sample_tick) begin
                if (last >= 0 && c - last != 3) bad++;
                last = c; cnt++;
            end
            @(negedge clk);
        end
        check(bad == 0 && cnt >= 99, "R3", "off-period intervals after upper-byte write", bad, 0);
    endtask

    task automatic t_zero_divisor();
        int ns, nb;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        count_ticks(150, ns, nb);
        check(ns == 0 && nb == 0, "R4", "ticks with zero divisor", ns + nb, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_hi_only_idle();
        t_basic();
        t_half_frac();
        t_max_rate();
        t_odd_fracs();
        t_large();
        t_hi_while_running();
        t_zero_divisor();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule